// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small cache of page table entries placed inside a memory management unit. A requester presents a virtual page number with an access type. The block picks one set using the low bits of the page number and compares the tag in every way of that set. On a hit it returns the cached physical page number and permission bits in the same cycle. It also checks the permissions against the access type and flags a protection fault when the access is not allowed. On a miss it raises a miss flag. A page table walker then fetches the entry with one memory access and installs it through the fill port.

Only the page number reaches the block. The page offset takes no part in indexing or tag comparison. Each line holds a valid bit, a tag, a physical page number and a permission field. A global flush input drops every entry in one cycle.

Top module: `tlb_sa`

## Requirements
- R1: After reset every line is invalid, so any lookup reports a miss until a fill has been made.
- R2: A lookup uses set index `lk_vpn[3:0]` and tag `lk_vpn[19:4]`. It hits only when a valid line in that set holds the same tag. Hit, miss and fault are combinational outputs in the cycle `lk_valid` is high, and all three are low while `lk_valid` is low.
- R3: On a hit, `lk_ppn` and `lk_perm` carry the physical page number and permission bits stored in the matching line.
- R4: A fill with `fill_valid` high at a clock edge installs its tag, page number and permissions into the set given by `fill_vpn[3:0]`. A lookup can see the new line from the next cycle on.
- R5: A fill with a new tag goes to the lowest-numbered invalid way of its set, when the set has one.
- R6: When all four ways of the set are valid, a per-set round-robin pointer chooses the victim. The pointer starts at way 0 after reset and advances by one, modulo 4, after each such replacement.
- R7: A fill whose tag already matches a valid way in its set overwrites that way and leaves the round-robin pointer unchanged, so a tag never appears twice in one set.
- R8: `flush` high at a clock edge clears every valid bit and leaves the round-robin pointers unchanged. A lookup in the same cycle as `flush` reports a miss. A fill in the same cycle as `flush` is dropped.
- R9: Permission bit 0 allows load, bit 1 allows store and bit 2 allows instruction fetch. Access type 0 is load, 1 is store, 2 is fetch, and 3 is reserved and never allowed. `lk_fault` is high only on a hit whose access type its permissions do not allow.
- R10: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_hit | output | 1 | Lookup found a valid matching line |
| lk_miss | output | 1 | Lookup found no matching line |
| lk_ppn | output | 20 | Physical page number of the matching line |
| lk_perm | output | 3 | Permission bits of the matching line |
| lk_fault | output | 1 | Hit, but the access type is not permitted |
| fill_valid | input | 1 | Install an entry from the page table walker |
| fill_vpn | input | 20 | Virtual page number of the entry to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_perm | input | 3 | Permission bits to install |
| flush | input | 1 | Invalidate every line |

## Verification
The embedded assertions check on every cycle that hit and miss are exclusive and complete, that a fault comes only with a hit, and that a flush leaves no valid line. They also check that each fill not cancelled by a flush is present one cycle later, and that no set ever holds the same tag twice. The victim order cannot be seen from a single cycle: lowest-invalid first, then round-robin rotation per set. Nor can a flush's priority over a simultaneous fill, the exact page numbers returned, or the permission encoding. These only show up in the bench's scenarios, where lines are filled past capacity, refilled and looked up again against an independent model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      req_tag_i,
    output logic [WAYS-1:0]       match_o,
    output logic                  any_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == req_tag_i);
    end
    assign any_o = |match_o;
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  vld_i,
    input  logic [WAYS-1:0]  match_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             adv_rr_o
);
    always_comb begin
        way_o    = rr_i;
        adv_rr_o = 1'b0;
        if (|match_i) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (match_i[w]) way_o = WAY_W'(w);
            end
        end else if (!(&vld_i)) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!vld_i[w]) way_o = WAY_W'(w);
            end
        end else begin
            adv_rr_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
    import tlb_pkg::*;
(
    input  logic [PERM_W-1:0] perm_i,
    input  logic [1:0]        acc_i,
    output logic              allow_o
);
    always_comb begin
        unique case (acc_e'(acc_i))
            ACC_LOAD:  allow_o = perm_i[PERM_RD];
            ACC_STORE: allow_o = perm_i[PERM_WR];
            ACC_FETCH: allow_o = perm_i[PERM_EX];
            default:   allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int SETS  = 16,
    parameter int WAYS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_fault,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct {
        logic [WAYS-1:0]   vld  [SETS];
        logic [TAG_W-1:0]  tag  [SETS][WAYS];
        logic [PPN_W-1:0]  ppn  [SETS][WAYS];
        logic [PERM_W-1:0] perm [SETS][WAYS];
        logic [WAY_W-1:0]  rr   [SETS];
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]       lk_set, fl_set;
    logic [TAG_W-1:0]       lk_tag, fl_tag;
    logic [WAYS*TAG_W-1:0]  lk_tags, fl_tags;
    logic [WAYS-1:0]        lk_match, fl_match;
    logic                   lk_any, fl_any;
    logic [WAY_W-1:0]       vic_way;
    logic                   vic_adv;
    logic [PPN_W-1:0]       sel_ppn;
    logic [PERM_W-1:0]      sel_perm;
    logic                   allow;

    assign lk_set = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_set = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_tags[w*TAG_W +: TAG_W] = st_q.tag[lk_set][w];
            fl_tags[w*TAG_W +: TAG_W] = st_q.tag[fl_set][w];
        end
    end

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld_i(st_q.vld[lk_set]), .tags_i(lk_tags), .req_tag_i(lk_tag),
        .match_o(lk_match), .any_o(lk_any)
    );

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .vld_i(st_q.vld[fl_set]), .tags_i(fl_tags), .req_tag_i(fl_tag),
        .match_o(fl_match), .any_o(fl_any)
    );

    tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .vld_i(st_q.vld[fl_set]), .match_i(fl_match), .rr_i(st_q.rr[fl_set]),
        .way_o(vic_way), .adv_rr_o(vic_adv)
    );

    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                sel_ppn  = sel_ppn  | st_q.ppn[lk_set][w];
                sel_perm = sel_perm | st_q.perm[lk_set][w];
            end
        end
    end

    tlb_perm_chk u_perm (.perm_i(sel_perm), .acc_i(lk_acc), .allow_o(allow));

    assign lk_hit   = lk_valid && lk_any && !flush;
    assign lk_miss  = lk_valid && !(lk_any && !flush);
    assign lk_ppn   = lk_hit ? sel_ppn  : '0;
    assign lk_perm  = lk_hit ? sel_perm : '0;
    assign lk_fault = lk_hit && !allow;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int s = 0; s < SETS; s++) st_d.vld[s] = '0;
        end else if (fill_valid) begin
            st_d.vld[fl_set][vic_way]  = 1'b1;
            st_d.tag[fl_set][vic_way]  = fl_tag;
            st_d.ppn[fl_set][vic_way]  = fill_ppn;
            st_d.perm[fl_set][vic_way] = fill_perm;
            if (vic_adv) st_d.rr[fl_set] = st_q.rr[fl_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st_q.vld[s] <= '0;
                st_q.rr[s]  <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    st_q.tag[s][w]  <= '0;
                    st_q.ppn[s][w]  <= '0;
                    st_q.perm[s][w] <= '0;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    logic any_vld;
    always_comb begin
        any_vld = 1'b0;
        for (int s = 0; s < SETS; s++) any_vld = any_vld | (|st_q.vld[s]);
    end

    logic             chk_fv_q;
    logic [IDX_W-1:0] chk_set_q;
    logic [TAG_W-1:0] chk_tag_q;
    logic             chk_present;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_fv_q  <= 1'b0;
            chk_set_q <= '0;
            chk_tag_q <= '0;
        end else begin
            chk_fv_q  <= fill_valid && !flush;
            chk_set_q <= fl_set;
            chk_tag_q <= fl_tag;
        end
    end
    always_comb begin
        chk_present = 1'b0;
        for (int w = 0; w < WAYS; w++)
            if (st_q.vld[chk_set_q][w] && st_q.tag[chk_set_q][w] == chk_tag_q) chk_present = 1'b1;
    end

    // R10
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
    // R9
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_vld);
    // R4
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fv_q |-> chk_present);

    // R7
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int a = 0; a < WAYS; a++)
                    for (int b = a + 1; b < WAYS; b++)
                        no_dup_tag_chk: assert (!(st_q.vld[s][a] && st_q.vld[s][b] &&
                                                  st_q.tag[s][a] == st_q.tag[s][b]));
        end
    end
endmodule

// File: tb/tlb_sa_tb_top.sv
module tlb_sa_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [19:0] lk_ppn;
    logic [2:0]  lk_perm;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush = 1'b0;

    always #2 clk = ~clk;

    tlb_sa dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .lk_fault(lk_fault), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush(flush)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit        hit;
        bit [19:0] ppn;
        bit [2:0]  perm;
        bit        fault;
        string     req;
    } exp_t;
    exp_t sb[$];

    // reference model
    bit        mv   [16][4];
    bit [15:0] mt   [16][4];
    bit [19:0] mp   [16][4];
    bit [2:0]  mperm[16][4];
    int        mrr  [16];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit allowed(input bit [2:0] p, input bit [1:0] a);
        case (a)
            2'd0: return p[0];
            2'd1: return p[1];
            2'd2: return p[2];
            default: return 1'b0;
        endcase
    endfunction

    task automatic cycle(input bit lv, input bit [19:0] lvpn, input bit [1:0] acc,
                         input bit fv, input bit [19:0] fvpn, input bit [19:0] fppn,
                         input bit [2:0] fperm, input bit fl, input string req);
        exp_t e;
        int s, t, way;
        bit found;
        @(posedge clk); #1;
        lk_valid = lv; lk_vpn = lvpn; lk_acc = acc;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm; flush = fl;
        if (lv) begin
            s = int'(lvpn[3:0]); t = int'(lvpn[19:4]);
            e.hit = 1'b0; e.ppn = '0; e.perm = '0; e.fault = 1'b0; e.req = req;
            if (!fl)
                for (int w = 0; w < 4; w++)
                    if (mv[s][w] && mt[s][w] == 16'(t)) begin
                        e.hit = 1'b1; e.ppn = mp[s][w]; e.perm = mperm[s][w];
                    end
            e.fault = e.hit && !allowed(e.perm, acc);
            sb.push_back(e);
        end
        if (fl) begin
            for (int i = 0; i < 16; i++) for (int w = 0; w < 4; w++) mv[i][w] = 1'b0;
        end else if (fv) begin
            s = int'(fvpn[3:0]); t = int'(fvpn[19:4]);
            found = 1'b0; way = 0;
            for (int w = 3; w >= 0; w--)
                if (mv[s][w] && mt[s][w] == 16'(t)) begin found = 1'b1; way = w; end
            if (!found)
                for (int w = 3; w >= 0; w--)
                    if (!mv[s][w]) begin found = 1'b1; way = w; end
            if (!found) begin way = mrr[s]; mrr[s] = (mrr[s] + 1) % 4; end
            mv[s][way] = 1'b1; mt[s][way] = 16'(t); mp[s][way] = fppn; mperm[s][way] = fperm;
        end
    endtask

    task automatic look(input bit [19:0] v, input bit [1:0] a, input string req);
        cycle(1'b1, v, a, 1'b0, '0, '0, '0, 1'b0, req);
    endtask
    task automatic fill(input bit [19:0] v, input bit [19:0] p, input bit [2:0] pm);
        cycle(1'b0, '0, 2'd0, 1'b1, v, p, pm, 1'b0, "");
    endtask
    task automatic idle();
        cycle(1'b0, '0, 2'd0, 1'b0, '0, '0, '0, 1'b0, "");
    endtask

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (rst_n && lk_valid && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(lk_hit == e.hit, e.req, "hit", 32'(lk_hit), 32'(e.hit));
            check(lk_miss == !e.hit, "R10", "miss", 32'(lk_miss), 32'(!e.hit));
            check(lk_fault == e.fault, e.req, "fault", 32'(lk_fault), 32'(e.fault));
            if (e.hit) begin
                check(lk_ppn == e.ppn, e.req, "ppn", 32'(lk_ppn), 32'(e.ppn));
                check(lk_perm == e.perm, e.req, "perm", 32'(lk_perm), 32'(e.perm));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf;
        for (int i = 0; i < 16; i++) begin
            mrr[i] = 0;
            for (int w = 0; w < 4; w++) begin mv[i][w] = 0; mt[i][w] = 0; mp[i][w] = 0; mperm[i][w] = 0; end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2 idle outputs quiet after reset
        check(!lk_hit && !lk_miss && !lk_fault, "R2", "idle outputs",
              {29'b0, lk_hit, lk_miss, lk_fault}, 32'd0);

        // R1 reset: everything misses
        look(20'h00000, 2'd0, "R1");
        look(20'h12343, 2'd0, "R1");

        // R4/R3 fill then hit
        fill(20'hABCD3, 20'h11111, 3'b111);
        look(20'hABCD3, 2'd0, "R3");
        // R2 same tag, other set misses; same set, other tag misses
        look(20'hABCD4, 2'd0, "R2");
        look(20'hABCE3, 2'd0, "R2");

        // R5 fill four ways of set 5 (lowest invalid first)
        for (int i = 0; i < 4; i++) fill({16'(16'h0100 + i), 4'h5}, 20'(20'h20000 + i), 3'b001);
        for (int i = 0; i < 4; i++) look({16'(16'h0100 + i), 4'h5}, 2'd0, "R5");
        // R6 fifth evicts way 0 (first tag), sixth evicts way 1
        fill({16'h0200, 4'h5}, 20'h30000, 3'b011);
        look({16'h0100, 4'h5}, 2'd0, "R6");
        look({16'h0101, 4'h5}, 2'd0, "R6");
        look({16'h0200, 4'h5}, 2'd1, "R6");
        fill({16'h0201, 4'h5}, 20'h30001, 3'b011);
        look({16'h0101, 4'h5}, 2'd0, "R6");
        look({16'h0102, 4'h5}, 2'd0, "R6");
        // R7 refill existing tag: updated in place, others untouched, rr unchanged
        fill({16'h0102, 4'h5}, 20'h4AAAA, 3'b100);
        look({16'h0102, 4'h5}, 2'd2, "R7");
        look({16'h0103, 4'h5}, 2'd0, "R7");
        look({16'h0200, 4'h5}, 2'd0, "R7");
        fill({16'h0300, 4'h5}, 20'h50000, 3'b001);   // rr at way 2 -> evicts tag 0x102
        look({16'h0102, 4'h5}, 2'd0, "R7");
        look({16'h0300, 4'h5}, 2'd0, "R7");

        // R9 permissions
        fill(20'h55557, 20'h0BEEF, 3'b010);
        look(20'h55557, 2'd0, "R9");
        look(20'h55557, 2'd1, "R9");
        look(20'h55557, 2'd2, "R9");
        look(20'h55557, 2'd3, "R9");
        fill(20'h66668, 20'h0CAFE, 3'b101);
        look(20'h66668, 2'd0, "R9");
        look(20'h66668, 2'd1, "R9");
        look(20'h66668, 2'd2, "R9");

        // R8 flush with same-cycle lookup, then miss afterwards
        cycle(1'b1, 20'hABCD3, 2'd0, 1'b0, '0, '0, '0, 1'b1, "R8");
        look(20'hABCD3, 2'd0, "R8");
        look({16'h0300, 4'h5}, 2'd0, "R8");
        // R8 fill dropped when flush coincides
        cycle(1'b0, '0, 2'd0, 1'b1, 20'h77779, 20'h0D00D, 3'b111, 1'b1, "R8");
        look(20'h77779, 2'd0, "R8");
        // R5 after flush fill goes to way 0; R6 pointer kept (set 5 rr at 3)
        for (int i = 0; i < 5; i++) fill({16'(16'h0400 + i), 4'h5}, 20'(20'h60000 + i), 3'b001);
        for (int i = 0; i < 5; i++) look({16'(16'h0400 + i), 4'h5}, 2'd0, "R6");

        // random traffic against the model: R2 R3 R4 R9
        lf = 32'hC0FFEE11;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            cycle(lf[0], {13'b0, lf[3:1], 2'b0, lf[5:4]}, lf[7:6],
                  lf[8], {13'b0, lf[11:9], 2'b0, lf[13:12]}, lf[31:12], lf[16:14],
                  (lf[27:22] == 6'd0), "R2 R3 R4 R9 random");
        end
        idle();
        @(posedge clk); @(negedge clk);
        check(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule